// File: doc/BRIEF.md
# I2C Master FIFO, Status and Interrupt Unit

This unit sits between a processor register bus and the serial engine of an I2C master. Software queues 11-bit command words (an opcode in the upper bits, a byte or count in the lower bits) into a transmit FIFO. The serial engine takes them from a valid/pop port. Bytes the engine receives are pushed into a receive FIFO, and software reads them back through a data register. That register also reports, in the same word, whether the FIFO had anything to give.

Two level flags compare each FIFO's occupancy against a programmable watermark. Three sticky flags record stop, NACK and arbitration-loss pulses from the engine, and software clears them by writing ones. The status word also mirrors two live busy inputs. An enable word masks the flags onto one registered interrupt line, and a control register empties either FIFO in one cycle.

Register byte offsets: parameter 0x00, control 0x04, status 0x08, interrupt enable 0x0C, FIFO control 0x10, FIFO status 0x14, transmit command 0x18, receive data 0x1C. A read request returns its data on `reg_rdata` at the next rising edge, and `reg_rdata` holds that value until the next read.

Top module: `i2cm_fifo_status`

## Requirements
- R1: After reset both FIFOs are empty, every sticky flag and the enable word (0x0C) are zero, `irq` is low, and status (0x08) reads 0x0000_0001.
- R2: Words written to 0x18 (bits 10:0) appear on `cmd_word` in write order while `cmd_valid` is high, one per cycle with `cmd_pop` high; a write when the FIFO holds its full depth is dropped.
- R3: A read of 0x1C returns the oldest received byte in bits 7:0 with bit 14 low and removes it; when the FIFO is empty the read returns 0x0000_4000; `rx_push` into a full FIFO is dropped.
- R4: FIFO status (0x14) gives the transmit entry count in bits 7:0 and the receive entry count in bits 23:16.
- R5: Status bit 0 is high exactly when the transmit count is at or below the transmit watermark, held in FIFO control (0x10) bits starting at bit 0.
- R6: Status bit 1 is high exactly when the receive count is above the receive watermark, held in FIFO control bits starting at bit 16.
- R7: Pulses on `ev_stop`, `ev_nack` and `ev_arb_lost` set status bits 9, 10 and 11; each stays set until a write to 0x08 with a one in that bit; writing zeros leaves them; a pulse in the same cycle as a clear wins.
- R8: Status bits 24 and 25 show `eng_busy` and `line_busy` as sampled at the read.
- R9: The enable word keeps only bits 0, 1, 9, 10 and 11 (a write of all ones reads back 0x0000_0E03); `irq` is high one cycle after any status bit and its enable bit are both high, and low when the enable word is zero.
- R10: Writing control (0x04) with bit 8 set empties the transmit FIFO and with bit 9 set empties the receive FIFO; a receive push in the same cycle as the flush is discarded.
- R11: The parameter register (0x00) gives log2 of the transmit depth in bits 3:0 and log2 of the receive depth in bits 11:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | Write when high, read when low |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| cmd_valid | output | 1 | Transmit FIFO holds a command |
| cmd_word | output | 11 | Oldest command word |
| cmd_pop | input | 1 | Engine takes the current command |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| ev_stop | input | 1 | Stop condition seen (pulse) |
| ev_nack | input | 1 | NACK seen (pulse) |
| ev_arb_lost | input | 1 | Arbitration lost (pulse) |
| eng_busy | input | 1 | Master engine busy |
| line_busy | input | 1 | Bus busy |
| irq | output | 1 | Registered interrupt request |

## Verification
The bound checker watches, on every cycle, that the transmit count never passes the depth and that a flush leaves an empty FIFO. It also checks that an empty receive read sets the empty bit, that sticky flags stay set without a clear, that the busy bits follow the inputs, and that a zero enable word keeps `irq` low. The bench scenarios cover what needs a history of traffic. These are the ordering of command words and received bytes through the scoreboards, the dropping of writes into full FIFOs, and the watermark boundaries. They also include the race between an event pulse and its clear, and a push racing a flush.

// File: rtl/i2cm_fifo_pkg.sv
package i2cm_fifo_pkg;
  localparam int REG_AW = 5;
  localparam int REG_DW = 32;
  localparam int CMD_W  = 11;
  localparam int BYTE_W = 8;

  localparam logic [REG_AW-1:0] A_PARAM    = 5'h00;
  localparam logic [REG_AW-1:0] A_CTRL     = 5'h04;
  localparam logic [REG_AW-1:0] A_STATUS   = 5'h08;
  localparam logic [REG_AW-1:0] A_IRQEN    = 5'h0C;
  localparam logic [REG_AW-1:0] A_FIFOCTL  = 5'h10;
  localparam logic [REG_AW-1:0] A_FIFOSTAT = 5'h14;
  localparam logic [REG_AW-1:0] A_TXCMD    = 5'h18;
  localparam logic [REG_AW-1:0] A_RXDATA   = 5'h1C;

  localparam int B_TXREQ    = 0;
  localparam int B_RXRDY    = 1;
  localparam int B_STOP     = 9;
  localparam int B_NACK     = 10;
  localparam int B_ARB      = 11;
  localparam int B_RXEMPTY  = 14;
  localparam int B_MBUSY    = 24;
  localparam int B_LBUSY    = 25;
  localparam int B_FLUSH_TX = 8;
  localparam int B_FLUSH_RX = 9;
  localparam int RX_LSB     = 16;

  localparam int EV_STOP = 0;
  localparam int EV_NACK = 1;
  localparam int EV_ARB  = 2;
  localparam int N_EV    = 3;

  localparam logic [REG_DW-1:0] IRQ_EN_MASK =
    (32'd1 << B_TXREQ) | (32'd1 << B_RXRDY) | (32'd1 << B_STOP) |
    (32'd1 << B_NACK) | (32'd1 << B_ARB);
endpackage

// File: rtl/i2cm_sync_fifo.sv
module i2cm_sync_fifo #(
  parameter int W  = 8,
  parameter int L2 = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [L2:0]   count,
  output logic          empty,
  output logic          full
);
  localparam int DEPTH = 1 << L2;
  localparam logic [L2:0] DEPTH_C = (L2+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [L2-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == DEPTH_C);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      count <= count + (L2+1)'(do_push) - (L2+1)'(do_pop);
    end
  end
endmodule

// File: rtl/i2cm_event_flags.sv
module i2cm_event_flags
  import i2cm_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EV-1:0]   ev_set,
  input  logic [N_EV-1:0]   ev_clr,
  input  logic              txreq,
  input  logic              rxrdy,
  input  logic              mbusy,
  input  logic              lbusy,
  input  logic [REG_DW-1:0] irq_en,
  output logic [REG_DW-1:0] status,
  output logic              irq
);
  logic [N_EV-1:0] sticky;
  localparam int EV_POS [N_EV] = '{B_STOP, B_NACK, B_ARB};

  always_ff @(posedge clk) begin
    if (rst) sticky <= '0;
    else     sticky <= ev_set | (sticky & ~ev_clr);
  end

  always_comb begin
    status          = '0;
    status[B_TXREQ] = txreq;
    status[B_RXRDY] = rxrdy;
    status[B_MBUSY] = mbusy;
    status[B_LBUSY] = lbusy;
    for (int i = 0; i < N_EV; i++) status[EV_POS[i]] = sticky[i];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & irq_en);
  end
endmodule

// File: rtl/i2cm_fifo_status.sv
module i2cm_fifo_status
  import i2cm_fifo_pkg::*;
#(
  parameter int TX_L2 = 2,
  parameter int RX_L2 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_word,
  input  logic              cmd_pop,
  input  logic              rx_push,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              ev_stop,
  input  logic              ev_nack,
  input  logic              ev_arb_lost,
  input  logic              eng_busy,
  input  logic              line_busy,
  output logic              irq
);
  localparam int TXC_W = TX_L2 + 1;
  localparam int RXC_W = RX_L2 + 1;

  logic wr, rd;
  logic [REG_DW-1:0] irq_en_q;
  logic [TX_L2-1:0]  tx_wm_q;
  logic [RX_L2-1:0]  rx_wm_q;
  logic              tx_flush, rx_flush, tx_push, rx_pop, rd_status;
  logic [TXC_W-1:0]  tx_cnt;
  logic [RXC_W-1:0]  rx_cnt;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [BYTE_W-1:0] rx_head;
  logic [N_EV-1:0]   ev_set, ev_clr;
  logic [REG_DW-1:0] status_w;
  logic              txreq, rxrdy;

  assign wr        = reg_req && reg_we;
  assign rd        = reg_req && !reg_we;
  assign tx_push   = wr && (reg_addr == A_TXCMD);
  assign tx_flush  = wr && (reg_addr == A_CTRL) && reg_wdata[B_FLUSH_TX];
  assign rx_flush  = wr && (reg_addr == A_CTRL) && reg_wdata[B_FLUSH_RX];
  assign rx_pop    = rd && (reg_addr == A_RXDATA);
  assign rd_status = rd && (reg_addr == A_STATUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en_q <= '0;
      tx_wm_q  <= '0;
      rx_wm_q  <= '0;
    end else if (wr) begin
      if (reg_addr == A_IRQEN) irq_en_q <= reg_wdata & IRQ_EN_MASK;
      if (reg_addr == A_FIFOCTL) begin
        tx_wm_q <= reg_wdata[TX_L2-1:0];
        rx_wm_q <= reg_wdata[RX_LSB +: RX_L2];
      end
    end
  end

  i2cm_sync_fifo #(.W(CMD_W), .L2(TX_L2)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(tx_push), .din(reg_wdata[CMD_W-1:0]),
    .pop(cmd_pop), .dout(cmd_word),
    .count(tx_cnt), .empty(tx_empty), .full(tx_full)
  );

  i2cm_sync_fifo #(.W(BYTE_W), .L2(RX_L2)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(rx_push), .din(rx_byte),
    .pop(rx_pop), .dout(rx_head),
    .count(rx_cnt), .empty(rx_empty), .full(rx_full)
  );

  assign cmd_valid = !tx_empty;
  assign txreq     = tx_cnt <= {1'b0, tx_wm_q};
  assign rxrdy     = rx_cnt > {1'b0, rx_wm_q};

  assign ev_set[EV_STOP] = ev_stop;
  assign ev_set[EV_NACK] = ev_nack;
  assign ev_set[EV_ARB]  = ev_arb_lost;

  always_comb begin
    ev_clr = '0;
    if (wr && reg_addr == A_STATUS) begin
      ev_clr[EV_STOP] = reg_wdata[B_STOP];
      ev_clr[EV_NACK] = reg_wdata[B_NACK];
      ev_clr[EV_ARB]  = reg_wdata[B_ARB];
    end
  end

  i2cm_event_flags u_flags (
    .clk(clk), .rst(rst), .ev_set(ev_set), .ev_clr(ev_clr),
    .txreq(txreq), .rxrdy(rxrdy), .mbusy(eng_busy), .lbusy(line_busy),
    .irq_en(irq_en_q), .status(status_w), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (rd) begin
      reg_rdata <= '0;
      case (reg_addr)
        A_PARAM: begin
          reg_rdata[3:0]  <= 4'(TX_L2);
          reg_rdata[11:8] <= 4'(RX_L2);
        end
        A_STATUS:  reg_rdata <= status_w;
        A_IRQEN:   reg_rdata <= irq_en_q;
        A_FIFOCTL: begin
          reg_rdata[TX_L2-1:0]       <= tx_wm_q;
          reg_rdata[RX_LSB +: RX_L2] <= rx_wm_q;
        end
        A_FIFOSTAT: begin
          reg_rdata[7:0]            <= 8'(tx_cnt);
          reg_rdata[RX_LSB +: 8]    <= 8'(rx_cnt);
        end
        A_RXDATA: begin
          reg_rdata[B_RXEMPTY] <= rx_empty;
          reg_rdata[7:0]       <= rx_empty ? '0 : rx_head;
        end
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/i2cm_fifo_status_chk.sv
module i2cm_fifo_status_chk #(
  parameter int TX_L2 = 2,
  parameter int RX_L2 = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic [31:0]      irq_en_q,
  input logic [31:0]      status_w,
  input logic [2:0]       ev_clr,
  input logic [TX_L2:0]   tx_cnt,
  input logic             tx_flush,
  input logic             rx_flush,
  input logic [RX_L2:0]   rx_cnt,
  input logic             rx_pop,
  input logic             rd_status,
  input logic [31:0]      reg_rdata,
  input logic             eng_busy,
  input logic             line_busy
);
  localparam logic [TX_L2:0] TX_DEPTH = (TX_L2+1)'(1 << TX_L2);

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    tx_cnt <= TX_DEPTH);

  a_r10_tx_flush_empty: assert property (@(posedge clk) disable iff (rst)
    tx_flush |=> (tx_cnt == '0));

  a_r10_rx_flush_empty: assert property (@(posedge clk) disable iff (rst)
    rx_flush |=> (rx_cnt == '0));

  a_r3_empty_read: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && rx_cnt == '0) |=> (reg_rdata == 32'h0000_4000));

  a_r7_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (status_w[10] && !ev_clr[1]) |=> status_w[10]);

  a_r8_busy_live: assert property (@(posedge clk) disable iff (rst)
    rd_status |=> (reg_rdata[24] == $past(eng_busy) &&
                   reg_rdata[25] == $past(line_busy)));

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (irq_en_q == '0) |=> !irq);
endmodule

bind i2cm_fifo_status i2cm_fifo_status_chk #(.TX_L2(TX_L2), .RX_L2(RX_L2)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .irq_en_q(irq_en_q), .status_w(status_w),
  .ev_clr(ev_clr), .tx_cnt(tx_cnt), .tx_flush(tx_flush), .rx_flush(rx_flush),
  .rx_cnt(rx_cnt), .rx_pop(rx_pop), .rd_status(rd_status),
  .reg_rdata(reg_rdata), .eng_busy(eng_busy), .line_busy(line_busy)
);

// File: tb/test_i2cm_fifo_status.sv
module test_i2cm_fifo_status;
  import i2cm_fifo_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_req = 0, reg_we = 0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic cmd_valid, cmd_pop;
  logic [10:0] cmd_word;
  logic rx_push = 0;
  logic [7:0] rx_byte = '0;
  logic ev_stop = 0, ev_nack = 0, ev_arb_lost = 0, eng_busy = 0, line_busy = 0;
  logic irq;

  int n_checks = 0, n_errs = 0;
  int tx_model = 0, rx_model = 0;
  bit pop_en = 0;
  logic [10:0] exp_cmd[$];
  logic [7:0]  exp_rx[$];
  logic [31:0] d;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cm_fifo_status i_i2cm_fifo_status (
    .clk(clk), .rst(rst), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_pop(cmd_pop),
    .rx_push(rx_push), .rx_byte(rx_byte), .ev_stop(ev_stop), .ev_nack(ev_nack),
    .ev_arb_lost(ev_arb_lost), .eng_busy(eng_busy), .line_busy(line_busy),
    .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [4:0] a, logic [31:0] v);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
  endtask

  task automatic reg_rd(logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_addr = a;
    @(negedge clk);
    reg_req = 0;
    v = reg_rdata;
  endtask

  task automatic push_cmd(logic [10:0] w);
    reg_wr(A_TXCMD, {21'h1FFFFF, w});
    if (tx_model < DEPTH) begin
      exp_cmd.push_back(w);
      tx_model++;
    end
  endtask

  task automatic rx_in(logic [7:0] b);
    @(negedge clk);
    rx_push = 1; rx_byte = b;
    @(negedge clk);
    rx_push = 0;
    if (rx_model < DEPTH) begin
      exp_rx.push_back(b);
      rx_model++;
    end
  endtask

  task automatic rx_read();
    logic [31:0] e;
    reg_rd(A_RXDATA, d);
    if (exp_rx.size() > 0) begin
      e = {24'h0, exp_rx.pop_front()};
      rx_model--;
    end else e = 32'h0000_4000;
    check("R3 rx read", d, e);
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    if (which == 0) ev_stop = 1;
    if (which == 1) ev_nack = 1;
    if (which == 2) ev_arb_lost = 1;
    @(negedge clk);
    ev_stop = 0; ev_nack = 0; ev_arb_lost = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
  endtask

  // monitor: engine model popping commands and scoring them
  initial begin
    cmd_pop = 0;
    forever begin
      @(negedge clk);
      cmd_pop = 0;
      if (pop_en && cmd_valid) begin
        n_checks++;
        if (exp_cmd.size() == 0) begin
          n_errs++;
          $display("FAIL R2 unexpected command actual=%h expected=none", cmd_word);
        end else begin
          logic [10:0] e;
          e = exp_cmd.pop_front();
          if (cmd_word !== e) begin
            n_errs++;
            $display("FAIL R2 command order actual=%h expected=%h", cmd_word, e);
          end
        end
        cmd_pop = 1;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_checks++; n_errs++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    // R1 reset state
    reg_rd(A_STATUS, d);   check("R1 status", d, 32'h1);
    reg_rd(A_FIFOSTAT, d); check("R1 fifo counts", d, 32'h0);
    reg_rd(A_IRQEN, d);    check("R1 enable", d, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    // R11 parameters
    reg_rd(A_PARAM, d);    check("R11 param", d, 32'h0202);
    // watermarks
    reg_wr(A_FIFOCTL, 32'h0001_0001);
    reg_rd(A_STATUS, d);   check("R5 empty below wm", d, 32'h1);
    // R2 fill past full
    push_cmd(11'h7A5); push_cmd(11'h123); push_cmd(11'h001);
    push_cmd(11'h3FF); push_cmd(11'h555);
    reg_rd(A_FIFOSTAT, d); check("R4 R2 tx count full", d, 32'h4);
    reg_rd(A_STATUS, d);   check("R5 above wm", d, 32'h0);
    check("R2 cmd_valid", {31'h0, cmd_valid}, 32'h1);
    pop_en = 1;
    repeat (10) @(negedge clk);
    pop_en = 0; tx_model = 0;
    check("R2 queue drained", exp_cmd.size(), 0);
    reg_rd(A_FIFOSTAT, d); check("R4 tx count drained", d, 32'h0);
    // R5 boundary
    push_cmd(11'h0AA);
    reg_rd(A_STATUS, d);   check("R5 at wm", d, 32'h1);
    push_cmd(11'h0BB);
    reg_rd(A_STATUS, d);   check("R5 one above wm", d, 32'h0);
    // R10 tx flush
    reg_wr(A_CTRL, 32'h100);
    exp_cmd.delete(); tx_model = 0;
    reg_rd(A_FIFOSTAT, d); check("R10 tx flushed", d, 32'h0);
    check("R10 cmd_valid low", {31'h0, cmd_valid}, 32'h0);
    // R6 / R3 receive
    rx_in(8'h11);
    reg_rd(A_STATUS, d);   check("R6 rx at wm", d, 32'h1);
    rx_in(8'h22);
    reg_rd(A_STATUS, d);   check("R6 rx above wm", d, 32'h3);
    reg_rd(A_FIFOSTAT, d); check("R4 rx count", d, 32'h0002_0000);
    rx_in(8'h33); rx_in(8'h44); rx_in(8'h55);
    reg_rd(A_FIFOSTAT, d); check("R4 R3 rx full", d, 32'h0004_0000);
    for (int i = 0; i < 5; i++) rx_read();
    // R10 rx flush racing a push
    rx_in(8'hA1);
    @(negedge clk);
    rx_push = 1; rx_byte = 8'hB2;
    reg_req = 1; reg_we = 1; reg_addr = A_CTRL; reg_wdata = 32'h200;
    @(negedge clk);
    rx_push = 0; reg_req = 0; reg_we = 0;
    exp_rx.delete(); rx_model = 0;
    reg_rd(A_FIFOSTAT, d); check("R10 rx flushed", d, 32'h0);
    rx_read();
    // R7 sticky flags
    pulse(1);
    reg_rd(A_STATUS, d);   check("R7 nack set", d, 32'h401);
    reg_wr(A_STATUS, 32'h0);
    reg_rd(A_STATUS, d);   check("R7 zero write ignored", d, 32'h401);
    reg_wr(A_STATUS, 32'h7F00);
    reg_rd(A_STATUS, d);   check("R7 clear all", d, 32'h1);
    pulse(2);
    reg_rd(A_STATUS, d);   check("R7 arb set", d, 32'h801);
    reg_wr(A_STATUS, 32'h800);
    pulse(1);
    @(negedge clk);
    ev_stop = 1;
    reg_req = 1; reg_we = 1; reg_addr = A_STATUS; reg_wdata = 32'h7F00;
    @(negedge clk);
    ev_stop = 0; reg_req = 0; reg_we = 0;
    reg_rd(A_STATUS, d);   check("R7 set beats clear", d, 32'h201);
    reg_wr(A_STATUS, 32'h200);
    // R8 busy
    eng_busy = 1;
    reg_rd(A_STATUS, d);   check("R8 engine busy", d, 32'h0100_0001);
    line_busy = 1;
    reg_rd(A_STATUS, d);   check("R8 line busy", d, 32'h0300_0001);
    eng_busy = 0; line_busy = 0;
    // R9 interrupt
    reg_wr(A_IRQEN, 32'hFFFF_FFFF);
    reg_rd(A_IRQEN, d);    check("R9 enable mask", d, 32'h0E03);
    check("R9 irq from txreq", {31'h0, irq}, 32'h1);
    reg_wr(A_IRQEN, 32'h400);
    @(negedge clk);
    check("R9 irq masked", {31'h0, irq}, 32'h0);
    pulse(1);
    @(negedge clk);
    check("R9 irq on nack", {31'h0, irq}, 32'h1);
    reg_wr(A_STATUS, 32'h400);
    @(negedge clk);
    check("R9 irq after clear", {31'h0, irq}, 32'h0);
    reg_wr(A_IRQEN, 32'h0);
    pulse(2);
    @(negedge clk);
    check("R9 all masked", {31'h0, irq}, 32'h0);
    summary();
    $finish;
  end
endmodule